// File: doc/BRIEF.md
# Packet classification search sequencer

This block runs the classification of one received packet at a time. An upstream parser gives it a raw identification key, a packet type and a protocol-error flag. The packet type picks a starting profile. The sequencer masks the key with that profile's mask, hashes the masked key with a 56-bit CRC and appends the 4-bit profile number to form a 60-bit search key. It presents this key on a request/acknowledge port to a tree-lookup memory. That port answers with hit status and the contents of a confirmation structure.

A hit is accepted only when three things hold: the stored header equals the masked key, the flow-table result is good, and the tree reported a hit. A confirmed hit either names a final destination or marks the search as an outer label lookup. In the label case the sequencer asks the parser to parse the packet again without that header, and then starts over. A miss, or a failed confirmation, falls back to the current profile's default structure. That structure either names a destination or sends the packet back through hashing under another profile. Every packet ends with a one-cycle completion pulse that carries a destination code, a structure pointer and an error flag.

Top module: `pkt_class_seq`

## Requirements
- R1: After reset `done`, `rp_req` and `srch_req` are low and `in_rdy` is high.
- R2: The search key is `{crc, profile}`, with the profile in bits 3:0 and the CRC in bits 59:4. The CRC is computed over `pkt_key & prof_mask`, most significant bit first, with the register preset to all ones and no final inversion. Each step computes `fb = crc[55] ^ bit` and `crc = (crc << 1) ^ (fb ? CRC_POLY : 0)`.
- R3: The first profile of a packet is nibble `pkt_type` of `INIT_PROF`, where nibble 0 is bits 3:0.
- R4: The first cycle of `srch_req` comes two cycles after the accepting edge. `srch_req` then stays high, with `srch_key` unchanged, until the cycle in which `srch_ack` is high.
- R5: A search is confirmed when three conditions hold at acknowledge: `srch_hit`, `cfm_flow_ok`, and `cfm_hdr` equal to the masked key. A confirmed search with `cfm_label` low completes with `cfm_dest` and `cfm_ptr`.
- R6: A miss, a header mismatch or a bad flow result uses the profile default. With `prof_redo` low, the packet completes with `prof_dest` and `prof_ptr`.
- R7: When the default has `prof_redo` high, the sequencer hashes and searches again under profile `prof_next`.
- R8: A confirmed search with `cfm_label` high raises `rp_req` for one cycle and waits for a new `pkt_valid`. It then restarts from the initial profile of the new packet type.
- R9: A packet gets at most 4 searches. If the decision after the 4th search asks for another pass, the packet completes with destination 1 (CPU), pointer 0 and `err` high.
- R10: When `pkt_perr` is high on an accepted `pkt_valid`, including a re-parse, no search is made. `done` follows in the next cycle with destination 1, pointer 0 and `err` low.
- R11: `done` is a one-cycle pulse in the cycle after the final decision, and `dest`, `dptr` and `err` are valid with it. Destination codes are: 0 for a transmit link buffer, 1 for the network CPU and 2 for the disassembly path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_rdy | output | 1 | Idle or waiting for a re-parse |
| pkt_valid | input | 1 | Parser fields valid |
| pkt_type | input | 2 | Packet type |
| pkt_key | input | 64 | Raw identification key |
| pkt_perr | input | 1 | Parser protocol error |
| prof_sel | output | 4 | Current profile index |
| prof_mask | input | 64 | Mask of selected profile |
| prof_redo | input | 1 | Default loops to another profile |
| prof_next | input | 4 | Profile for the next pass |
| prof_dest | input | 2 | Default destination |
| prof_ptr | input | 20 | Default structure pointer |
| srch_req | output | 1 | Tree search request |
| srch_key | output | 60 | Search key |
| srch_ack | input | 1 | Tree answer valid |
| srch_hit | input | 1 | Key found |
| cfm_hdr | input | 64 | Header stored in confirmation structure |
| cfm_flow_ok | input | 1 | Flow-table result good |
| cfm_label | input | 1 | Entry is an outer label |
| cfm_dest | input | 2 | Confirmed destination |
| cfm_ptr | input | 20 | Confirmed structure pointer |
| rp_req | output | 1 | Re-parse request pulse |
| done | output | 1 | Classification complete |
| dest | output | 2 | Destination code |
| dptr | output | 20 | Destination structure pointer |
| err | output | 1 | Pass limit exceeded |

## Verification
The bench sends a set of packets through the sequencer, each chosen to steer a different path:
- a direct confirmed hit;
- a plain miss;
- a hit whose stored header differs from the masked key;
- a hit with a bad flow result;
- a default that jumps to another profile;
- an outer label followed by a re-parse;
- profile loops and label loops that reach the pass limit from each side;
- protocol errors on the first parse and on a re-parse.

A reference model predicts, cycle by cycle, the request, re-parse and completion strobes, together with the exact search key. Comparing these shows whether the masking, the hashing and the profile order are right, and whether the pass count is kept across both kinds of loop. The miss, mismatch and flow cases end up at the same default, but reach it through separate terms of the confirmation test. Running under several tree latencies shows whether the key is held while the request waits for its answer.

// File: rtl/pkt_class_seq.sv
module pkt_class_seq #(
  parameter int KEY_W = 64,
  parameter int TYPE_W = 2,
  parameter int PROF_W = 4,
  parameter int HASH_W = 56,
  parameter int PTR_W = 20,
  parameter int MAX_PASS = 4,
  parameter logic [HASH_W-1:0] CRC_POLY = 56'h42F0E1EBA9EA37,
  parameter logic [(1<<TYPE_W)*PROF_W-1:0] INIT_PROF = 16'h5A31
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              in_rdy,
  input  logic              pkt_valid,
  input  logic [TYPE_W-1:0] pkt_type,
  input  logic [KEY_W-1:0]  pkt_key,
  input  logic              pkt_perr,
  output logic [PROF_W-1:0] prof_sel,
  input  logic [KEY_W-1:0]  prof_mask,
  input  logic              prof_redo,
  input  logic [PROF_W-1:0] prof_next,
  input  logic [1:0]        prof_dest,
  input  logic [PTR_W-1:0]  prof_ptr,
  output logic              srch_req,
  output logic [HASH_W+PROF_W-1:0] srch_key,
  input  logic              srch_ack,
  input  logic              srch_hit,
  input  logic [KEY_W-1:0]  cfm_hdr,
  input  logic              cfm_flow_ok,
  input  logic              cfm_label,
  input  logic [1:0]        cfm_dest,
  input  logic [PTR_W-1:0]  cfm_ptr,
  output logic              rp_req,
  output logic              done,
  output logic [1:0]        dest,
  output logic [PTR_W-1:0]  dptr,
  output logic              err
);
  localparam int SKEY_W = HASH_W + PROF_W;
  localparam int PASS_W = $clog2(MAX_PASS + 1);
  localparam logic [1:0] DST_CPU = 2'd1;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_SRCH, S_WAIT} st_t;

  st_t               st;
  logic [KEY_W-1:0]  key_r, mkey;
  logic [PROF_W-1:0] prof;
  logic [PASS_W-1:0] pass;
  logic [SKEY_W-1:0] skey;
  logic              cfm_ok, want_loop, at_cap;

  function automatic logic [HASH_W-1:0] crc_fn(input logic [KEY_W-1:0] d);
    logic [HASH_W-1:0] c;
    logic fb;
    c = '1;
    for (int i = KEY_W - 1; i >= 0; i--) begin
      fb = c[HASH_W-1] ^ d[i];
      c = {c[HASH_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  assign in_rdy    = (st == S_IDLE) || (st == S_WAIT);
  assign srch_req  = (st == S_SRCH);
  assign srch_key  = skey;
  assign prof_sel  = prof;
  assign cfm_ok    = srch_hit && cfm_flow_ok && (cfm_hdr == mkey);
  assign want_loop = cfm_ok ? cfm_label : prof_redo;
  assign at_cap    = (pass == PASS_W'(MAX_PASS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      key_r  <= '0;
      mkey   <= '0;
      prof   <= '0;
      pass   <= '0;
      skey   <= '0;
      rp_req <= 1'b0;
      done   <= 1'b0;
      dest   <= '0;
      dptr   <= '0;
      err    <= 1'b0;
    end else begin
      done   <= 1'b0;
      rp_req <= 1'b0;
      case (st)
        S_IDLE, S_WAIT: begin
          if (pkt_valid) begin
            key_r <= pkt_key;
            prof  <= INIT_PROF[integer'(pkt_type)*PROF_W +: PROF_W];
            if (st == S_IDLE) pass <= '0;
            if (pkt_perr) begin
              done <= 1'b1;
              dest <= DST_CPU;
              dptr <= '0;
              err  <= 1'b0;
              st   <= S_IDLE;
            end else begin
              st <= S_HASH;
            end
          end
        end
        S_HASH: begin
          mkey <= key_r & prof_mask;
          skey <= {crc_fn(key_r & prof_mask), prof};
          pass <= pass + 1'b1;
          st   <= S_SRCH;
        end
        S_SRCH: begin
          if (srch_ack) begin
            if (want_loop && at_cap) begin
              done <= 1'b1;
              dest <= DST_CPU;
              dptr <= '0;
              err  <= 1'b1;
              st   <= S_IDLE;
            end else if (cfm_ok && cfm_label) begin
              rp_req <= 1'b1;
              st     <= S_WAIT;
            end else if (cfm_ok) begin
              done <= 1'b1;
              dest <= cfm_dest;
              dptr <= cfm_ptr;
              err  <= 1'b0;
              st   <= S_IDLE;
            end else if (prof_redo) begin
              prof <= prof_next;
              st   <= S_HASH;
            end else begin
              done <= 1'b1;
              dest <= prof_dest;
              dptr <= prof_ptr;
              err  <= 1'b0;
              st   <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_req && !srch_ack |=> srch_req && $stable(srch_key));
  // R9
  pass_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass <= PASS_W'(MAX_PASS));
  // R10
  perr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy && pkt_valid && pkt_perr |=> done && dest == DST_CPU && !err);
  // R8
  rp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_req |-> !done && !srch_req && in_rdy);
  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !srch_req && !rp_req);
  // R9
  err_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> dest == DST_CPU && dptr == '0);
endmodule

// File: tb/sim_pkt_class_seq.sv
`timescale 1ns/1ps
module sim_pkt_class_seq;
  localparam logic [55:0] POLY = 56'h42F0E1EBA9EA37;
  localparam logic [15:0] BINIT = 16'h5A31;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_rdy, pkt_valid = 0, pkt_perr = 0;
  logic [1:0] pkt_type = 0;
  logic [63:0] pkt_key = 0;
  logic [3:0] prof_sel, prof_next;
  logic [63:0] prof_mask, cfm_hdr;
  logic prof_redo, srch_req, srch_ack, srch_hit, cfm_flow_ok, cfm_label;
  logic [1:0] prof_dest, cfm_dest, dest;
  logic [19:0] prof_ptr, cfm_ptr, dptr;
  logic [59:0] srch_key;
  logic rp_req, done, err;

  logic [63:0] pm [16];
  logic        pact [16];
  logic [3:0]  pnx [16];
  logic [1:0]  pds [16];
  logic [19:0] ppt [16];
  logic [59:0] tk [8];
  logic        tv [8], tfl [8], tlb [8];
  logic [63:0] thd [8];
  logic [1:0]  tds [8];
  logic [19:0] tpt [8];
  int tlat = 0, wcnt = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;

  pkt_class_seq #(.INIT_PROF(BINIT)) u0 (.*);

  function automatic logic [55:0] bcrc(input logic [63:0] d);
    logic [55:0] c = '1;
    for (int i = 63; i >= 0; i--) begin
      logic f = c[55] ^ d[i];
      c = c << 1;
      if (f) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic int tfind(input logic [59:0] k);
    for (int i = 0; i < 8; i++) if (tv[i] && tk[i] == k) return i;
    return -1;
  endfunction

  assign prof_mask = pm[prof_sel];
  assign prof_redo = pact[prof_sel];
  assign prof_next = pnx[prof_sel];
  assign prof_dest = pds[prof_sel];
  assign prof_ptr  = ppt[prof_sel];
  assign srch_ack  = srch_req && (wcnt == tlat);

  always_comb begin
    int ix;
    ix = tfind(srch_key);
    srch_hit = ix >= 0;
    cfm_hdr = ix >= 0 ? thd[ix] : '0;
    cfm_flow_ok = ix >= 0 ? tfl[ix] : 1'b0;
    cfm_label = ix >= 0 ? tlb[ix] : 1'b0;
    cfm_dest = ix >= 0 ? tds[ix] : 2'd0;
    cfm_ptr = ix >= 0 ? tpt[ix] : '0;
  end

  always @(posedge clk) wcnt <= (srch_req && !srch_ack) ? wcnt + 1 : 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] ex);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, ex);
    end
  endtask

  task automatic add_ent(input int i, input logic [3:0] p, input logic [63:0] k, input logic bad,
                         input logic fl, input logic lb, input logic [1:0] ds, input logic [19:0] pt);
    logic [63:0] m = k & pm[p];
    tk[i] = {bcrc(m), p}; tv[i] = 1; thd[i] = m ^ {63'b0, bad};
    tfl[i] = fl; tlb[i] = lb; tds[i] = ds; tpt[i] = pt;
  endtask

  logic [62:0] exq [$];
  logic [1:0] x_dest; logic [19:0] x_ptr; logic x_err;

  task automatic model(input logic [1:0] ty, input logic [63:0] k, input logic pe,
                       input logic [1:0] ity, input logic [63:0] ik, input logic ipe);
    int pass = 0;
    logic [1:0] cty = ty; logic [63:0] ck = k; logic cpe = pe;
    exq.delete();
    forever begin
      logic [3:0] p;
      logic relab = 0;
      if (cpe) begin
        exq.push_back({3'b001, 60'b0}); x_dest = 1; x_ptr = 0; x_err = 0; return;
      end
      p = BINIT[cty*4 +: 4];
      while (!relab) begin
        logic [63:0] mk = ck & pm[p];
        logic [59:0] sk = {bcrc(mk), p};
        int ix; logic ok, want;
        exq.push_back({3'b000, 60'b0});
        pass++;
        for (int j = 0; j <= tlat; j++) exq.push_back({3'b100, sk});
        ix = tfind(sk);
        ok = ix >= 0 && thd[ix] == mk && tfl[ix];
        want = ok ? tlb[ix] : pact[p];
        if (want && pass == 4) begin
          exq.push_back({3'b001, 60'b0}); x_dest = 1; x_ptr = 0; x_err = 1; return;
        end
        if (ok && !tlb[ix]) begin
          exq.push_back({3'b001, 60'b0}); x_dest = tds[ix]; x_ptr = tpt[ix]; x_err = 0; return;
        end
        if (ok) begin
          exq.push_back({3'b010, 60'b0}); relab = 1;
          cty = ity; ck = ik; cpe = ipe;
        end else if (pact[p]) p = pnx[p];
        else begin
          exq.push_back({3'b001, 60'b0}); x_dest = pds[p]; x_ptr = ppt[p]; x_err = 0; return;
        end
      end
    end
  endtask

  task automatic run(input string tag, input int lat, input logic [1:0] ty, input logic [63:0] k,
                     input logic pe, input logic [1:0] ity, input logic [63:0] ik, input logic ipe);
    logic [62:0] e;
    tlat = lat;
    model(ty, k, pe, ity, ik, ipe);
    @(negedge clk);
    pkt_valid = 1; pkt_type = ty; pkt_key = k; pkt_perr = pe;
    while (exq.size() > 0) begin
      @(negedge clk);
      pkt_valid = 0;
      e = exq.pop_front();
      chk(srch_req == e[62], {tag, " R4 srch_req"}, srch_req, e[62]);
      chk(rp_req == e[61], {tag, " R8 rp_req"}, rp_req, e[61]);
      chk(done == e[60], {tag, " R11 done"}, done, e[60]);
      if (e[62]) chk(srch_key == e[59:0], {tag, " R2 srch_key"}, srch_key, e[59:0]);
      if (e[60]) begin
        chk(dest == x_dest, {tag, " dest"}, dest, x_dest);
        chk(dptr == x_ptr, {tag, " dptr"}, dptr, x_ptr);
        chk(err == x_err, {tag, " err"}, err, x_err);
      end
      if (rp_req) begin
        pkt_valid = 1; pkt_type = ity; pkt_key = ik; pkt_perr = ipe;
      end
    end
    @(negedge clk);
    pkt_valid = 0;
    chk(!done && in_rdy, {tag, " R11 idle after"}, {done, in_rdy}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      pm[i] = '1; pact[i] = 0; pnx[i] = 0; pds[i] = 0; ppt[i] = 20'h100 + i;
    end
    for (int i = 0; i < 8; i++) tv[i] = 0;
    pm[1] = 64'hFFFF_FFFF_0000_FFFF;
    pm[3] = 64'h0000_FFFF_FFFF_FFFF;
    pds[3] = 2'd0; ppt[3] = 20'h00077;
    pact[10] = 1; pnx[10] = 4'd5;
    pact[5] = 1; pnx[5] = 4'd12;
    pact[12] = 1; pnx[12] = 4'd12;
    add_ent(0, 4'd1, 64'h1111_2222_3333_4444, 0, 1, 0, 2'd2, 20'h01234);
    add_ent(1, 4'd3, 64'hC0C0_0000_1234_5678, 1, 1, 0, 2'd2, 20'h0AAAA);
    add_ent(2, 4'd3, 64'hC0C0_0000_8765_4321, 0, 0, 0, 2'd2, 20'h0BBBB);
    add_ent(3, 4'd5, 64'hDDDD_0000_0000_0001, 0, 1, 0, 2'd2, 20'h02222);
    add_ent(4, 4'd1, 64'hEEEE_0000_0000_0001, 0, 1, 1, 2'd0, 20'h00000);
    add_ent(5, 4'd1, 64'hEEEE_0000_0000_0002, 0, 1, 0, 2'd0, 20'h03333);
    add_ent(6, 4'd1, 64'h6666_0000_0000_0006, 0, 1, 1, 2'd0, 20'h00000);

    repeat (3) @(negedge clk);
    chk(!done && !rp_req && !srch_req && in_rdy, "R1 reset",
        {done, rp_req, srch_req, in_rdy}, 4'b0001);
    rst_n = 1;
    // R5 R3: type 0 starts on profile 1, confirmed hit to disassembly
    run("R5 hit", 0, 2'd0, 64'h1111_2222_3333_4444, 0, 0, 0, 0);
    run("R5 hit lat3", 3, 2'd0, 64'h1111_2222_3333_4444, 0, 0, 0, 0);
    // R3 R2: masked-out bits do not change the key
    run("R3 masked", 1, 2'd0, 64'h1111_2222_FFFF_4444, 0, 0, 0, 0);
    // R6: miss, header mismatch, flow failure
    run("R6 miss", 2, 2'd1, 64'h0000_0000_0000_0099, 0, 0, 0, 0);
    run("R6 hdr", 0, 2'd1, 64'hC0C0_0000_1234_5678, 0, 0, 0, 0);
    run("R6 flow", 1, 2'd1, 64'hC0C0_0000_8765_4321, 0, 0, 0, 0);
    // R7: profile 10 misses, default sends to profile 5
    run("R7 research", 0, 2'd2, 64'hDDDD_0000_0000_0001, 0, 0, 0, 0);
    // R8: outer label then inner hit
    run("R8 reparse", 1, 2'd0, 64'hEEEE_0000_0000_0001, 0, 2'd0, 64'hEEEE_0000_0000_0002, 0);
    // R9: profile loop and label loop hit the cap
    run("R9 prof cap", 0, 2'd3, 64'h0000_0000_0000_0123, 0, 0, 0, 0);
    run("R9 label cap", 2, 2'd0, 64'h6666_0000_0000_0006, 0, 2'd0, 64'h6666_0000_0000_0006, 0);
    // R10: parser error, first parse and re-parse
    run("R10 perr", 0, 2'd0, 64'h1111_2222_3333_4444, 1, 0, 0, 0);
    run("R10 perr reparse", 0, 2'd0, 64'hEEEE_0000_0000_0001, 0, 2'd0, 64'h0, 1);
    run("R5 after", 0, 2'd0, 64'h1111_2222_3333_4444, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule